// File: doc/BRIEF.md
# Delayed Request Discard Timer

This block watches the entry at the front of a bridge's delayed-request queue. It counts clocks from the moment the entry reaches the front. If the initiator that issued the request has not come back to retry it by the time the count expires, the block raises a one-clock discard pulse so the queue can drop the stale entry.

The queue asserts `head_valid` while an entry sits at the front. It pulses `retry_seen` when the initiator repeats the request, and pulses `entry_clear` when the entry completes. The control bit `short_sel` chooses between a long limit of 2^LONG_EXP clocks and a short limit of 2^SHORT_EXP clocks. The block samples that bit once, at the start of each countdown.

Top module: `dt_discard_timer`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after reset is released, `discard` and `active` are both 0.
- R2: In the idle state, a clock edge that samples `head_valid`=1 and `entry_clear`=0 starts a countdown, and `active` is 1 from that edge onward.
- R3: When `short_sel`=1 at the start edge, `discard` rises exactly 2^SHORT_EXP (1024 by default) clock edges after the start edge, provided no retry, clear or drop of `head_valid` comes first.
- R4: When `short_sel`=0 at the start edge, `discard` rises exactly 2^LONG_EXP (32768 by default) edges after the start edge. `short_sel`=0 is the selection used after reset.
- R5: `discard` is high for exactly one cycle, and `active` falls at the same edge that raises it.
- R6: A `retry_seen`=1 sampled while counting ends the countdown with no discard. This holds even when the retry arrives on the edge on which the count would have expired.
- R7: `head_valid`=0 or `entry_clear`=1 sampled while counting returns the block to idle with no discard. A later start counts the full limit again from zero.
- R8: A change of `short_sel` after the start edge does not alter the limit of the countdown in progress.
- R9: After a discard or a retry, no new countdown starts until `head_valid`=0 or `entry_clear`=1 has been sampled.
- R10: `retry_seen` has no effect when the block is not counting, including on the start edge itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_valid | input | 1 | A delayed entry is at the front of the queue |
| retry_seen | input | 1 | Pulse: the initiator repeated the front entry's request |
| entry_clear | input | 1 | Pulse: the front entry completed |
| short_sel | input | 1 | Limit select: 1 gives 2^SHORT_EXP clocks, 0 gives 2^LONG_EXP clocks |
| discard | output | 1 | One-clock pulse: drop the front entry |
| active | output | 1 | Countdown in progress |

## Verification
On every cycle the assertions check four things. A discard lasts one cycle. A discard only ends an active run, and that run is exactly as long as the limit latched at its start. A retry, a clear or a drop of `head_valid` during a countdown ends it with no discard. Other behaviour only the bench's scenarios can show: the boundary retry on the expiry edge, the select bit flipping partway through a count, the halted state after a discard or retry holding off a restart, and retries while idle being ignored.

// File: rtl/dt_discard_timer.sv
module dt_discard_timer #(
  parameter int LONG_EXP  = 15,
  parameter int SHORT_EXP = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic head_valid,
  input  logic retry_seen,
  input  logic entry_clear,
  input  logic short_sel,
  output logic discard,
  output logic active
);
  localparam int CW = LONG_EXP;
  localparam logic [CW-1:0] LONG_LAST  = {CW{1'b1}};
  localparam logic [CW-1:0] SHORT_LAST = CW'((1 << SHORT_EXP) - 1);

  typedef enum logic [1:0] {IDLE, RUN, HALT} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          sel_q;
  logic          discard_q;
  logic          leave;
  logic [CW-1:0] last;

  assign leave   = !head_valid || entry_clear;
  assign last    = sel_q ? SHORT_LAST : LONG_LAST;
  assign discard = discard_q;
  assign active  = (st == RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= IDLE;
      cnt       <= '0;
      sel_q     <= 1'b0;
      discard_q <= 1'b0;
    end else begin
      discard_q <= 1'b0;
      case (st)
        IDLE: if (!leave) begin
          st    <= RUN;
          cnt   <= '0;
          sel_q <= short_sel;
        end
        RUN: begin
          if (leave) begin
            st  <= IDLE;
            cnt <= '0;
          end else if (retry_seen) begin
            st  <= HALT;
            cnt <= '0;
          end else if (cnt == last) begin
            st        <= HALT;
            cnt       <= '0;
            discard_q <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        HALT: if (leave) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dt_discard_timer_chk.sv
module dt_discard_timer_chk #(
  parameter int LONG_EXP  = 15,
  parameter int SHORT_EXP = 10
) (
  input logic clk,
  input logic rst_n,
  input logic head_valid,
  input logic retry_seen,
  input logic entry_clear,
  input logic short_sel,
  input logic discard,
  input logic active
);
  localparam logic [31:0] LONG_LIM  = 32'(1) << LONG_EXP;
  localparam logic [31:0] SHORT_LIM = 32'(1) << SHORT_EXP;

  logic [31:0] run;
  logic        sel_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run   <= '0;
      sel_c <= 1'b0;
    end else begin
      run <= active ? run + 1 : '0;
      if (!active) sel_c <= short_sel;
    end
  end

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    discard |=> !discard);

  assert_discard_ends_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    discard |-> (!active && $past(active)));

  assert_limit_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (discard && sel_c) |-> (run == SHORT_LIM));

  assert_limit_exact_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (discard && !sel_c) |-> (run == LONG_LIM));

  assert_run_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (run < (sel_c ? SHORT_LIM : LONG_LIM)));

  assert_retry_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && head_valid && !entry_clear && retry_seen) |=> (!active && !discard));

  assert_leave_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && (!head_valid || entry_clear)) |=> (!active && !discard));

  assert_idle_no_discard_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !discard);
endmodule

bind dt_discard_timer dt_discard_timer_chk #(.LONG_EXP(LONG_EXP), .SHORT_EXP(SHORT_EXP)) u_chk (
  .clk(clk), .rst_n(rst_n), .head_valid(head_valid), .retry_seen(retry_seen),
  .entry_clear(entry_clear), .short_sel(short_sel), .discard(discard), .active(active)
);

// File: tb/tb_dt_discard_timer.sv
module tb_dt_discard_timer;
  localparam int LONG_LIM  = 32768;
  localparam int SHORT_LIM = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic head_valid = 1'b0, retry_seen = 1'b0, entry_clear = 1'b0, short_sel = 1'b0;
  logic discard, active;

  int checks = 0, errors = 0, cyc_n = 0, disc_seen = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  dt_discard_timer dut (
    .clk(clk), .rst_n(rst_n), .head_valid(head_valid), .retry_seen(retry_seen),
    .entry_clear(entry_clear), .short_sel(short_sel), .discard(discard), .active(active)
  );

  // behavioural reference: 0 idle, 1 counting, 2 halted
  int m_state = 0, m_elapsed = 0, m_lim = LONG_LIM;
  bit exp_disc = 0;

  always @(posedge clk) begin
    exp_disc = 0;
    if (!rst_n) begin
      m_state = 0; m_elapsed = 0;
    end else if (m_state == 0) begin
      if (head_valid && !entry_clear) begin
        m_state = 1; m_elapsed = 0;
        m_lim = short_sel ? SHORT_LIM : LONG_LIM;
      end
    end else if (m_state == 1) begin
      m_elapsed++;
      if (!head_valid || entry_clear) m_state = 0;
      else if (retry_seen) m_state = 2;
      else if (m_elapsed == m_lim) begin m_state = 2; exp_disc = 1; end
    end else if (!head_valid || entry_clear) m_state = 0;
  end

  task automatic chk(string req, int act, int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (t=%0t)", req, act, exp_v, $time);
    end
  endtask

  always @(negedge clk) begin
    chk(cur_req, int'(discard), int'(exp_disc));
    chk(cur_req, int'(active), int'(m_state == 1));
    if (discard) disc_seen++;
  end

  always @(posedge clk) begin
    cyc_n++;
    if (cyc_n > 190000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected below 190000 cycles", cyc_n);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic retire();
    head_valid = 0; tick(2);
  endtask

  initial begin
    tick(3);
    chk("R1", int'(discard), 0);
    chk("R1", int'(active), 0);
    rst_n = 1; tick(1);
    chk("R1", int'(active), 0);

    // R4 long default limit
    cur_req = "R4"; disc_seen = 0;
    head_valid = 1; tick(1);
    chk("R2", int'(active), 1);
    tick(LONG_LIM + 4);
    chk("R4", disc_seen, 1);
    retire();

    // R3 short limit, R5 single pulse
    cur_req = "R3"; disc_seen = 0; short_sel = 1;
    head_valid = 1; tick(SHORT_LIM + 4);
    chk("R5", disc_seen, 1);
    // R9 halted while head stays valid after discard
    cur_req = "R9"; tick(SHORT_LIM + 10);
    chk("R9", disc_seen, 1);
    chk("R9", int'(active), 0);
    retire();

    // R6 retry mid count, then halt holds
    cur_req = "R6"; disc_seen = 0;
    head_valid = 1; tick(500);
    retry_seen = 1; tick(1); retry_seen = 0;
    chk("R6", int'(active), 0);
    tick(2 * SHORT_LIM);
    chk("R6", disc_seen, 0);
    retire();

    // R6 retry on the expiry edge
    cur_req = "R6"; disc_seen = 0;
    head_valid = 1; tick(1); tick(SHORT_LIM - 1);
    retry_seen = 1; tick(1); retry_seen = 0;
    tick(4);
    chk("R6", disc_seen, 0);
    retire();

    // R7 head drop mid count, then full recount
    cur_req = "R7"; disc_seen = 0;
    head_valid = 1; tick(800);
    head_valid = 0; tick(1);
    chk("R7", int'(active), 0);
    head_valid = 1; tick(SHORT_LIM - 2);
    chk("R7", disc_seen, 0);
    tick(6);
    chk("R7", disc_seen, 1);
    retire();

    // R7 clear pulse mid count
    cur_req = "R7"; disc_seen = 0;
    head_valid = 1; tick(300);
    entry_clear = 1; tick(1); entry_clear = 0;
    chk("R7", int'(active), 0);
    retire();
    chk("R7", disc_seen, 0);

    // R8 select flips mid count (short start)
    cur_req = "R8"; disc_seen = 0; short_sel = 1;
    head_valid = 1; tick(100);
    short_sel = 0; tick(SHORT_LIM);
    chk("R8", disc_seen, 1);
    retire();

    // R8 select flips mid count (long start)
    cur_req = "R8"; disc_seen = 0; short_sel = 0;
    head_valid = 1; tick(100);
    short_sel = 1; tick(SHORT_LIM * 2);
    chk("R8", disc_seen, 0);
    chk("R8", int'(active), 1);
    tick(LONG_LIM);
    chk("R8", disc_seen, 1);
    retire();

    // R10 retries while idle and on the start edge are ignored
    cur_req = "R10"; disc_seen = 0; short_sel = 1;
    retry_seen = 1; tick(3);
    head_valid = 1; tick(1); retry_seen = 0;
    chk("R10", int'(active), 1);
    tick(SHORT_LIM + 2);
    chk("R10", disc_seen, 1);
    retire();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule